// File: doc/BRIEF.md
# SDRAM Byte-Lane Data Mask Path

This block sits on the data side of a 16-bit synchronous DRAM interface. It applies a two-bit byte mask to both directions of traffic. Each mask bit governs one byte lane. A high mask bit blocks its lane and a low bit lets the lane through. The decision is made separately for every beat of a burst.

On the write side the mask has no latency. The mask sampled at a clock edge decides, in the same cycle, whether each byte of the incoming beat is stored into the array model. On the read side the mask is delayed by a two-stage per-lane shift register. The delayed value gates the output enable of each byte lane, and a lane without enable drives zero on its data pins. Command decoding and array timing stay outside the block. It receives only burst-active strobes from a sequencer and read data from an array model.

Top module: `sdram_dq_mask_path`

## Requirements
- R1: Mask bit 0 governs data bits 7:0 and mask bit 1 governs data bits 15:8. Lane l covers bits 8l+7 down to 8l, and a mask on one lane never affects the other lane.
- R2: While `wr_burst_i` is high, `arr_wr_be_o[l]` is 1 in the same cycle exactly when `mask_i[l]` is 0, so there is no mask latency on writes.
- R3: `arr_wr_data_o` equals `wr_data_i` in the same cycle.
- R4: While `wr_burst_i` is low, `arr_wr_be_o` is 2'b00 whatever `mask_i` holds.
- R5: A mask bit sampled high at clock edge k clears `dq_oe_o` of its lane in the cycle that follows edge k+1. That is the beat the controller captures at edge k+2, which gives a read mask latency of two cycles. A bit sampled low there enables the lane if a read burst is active.
- R6: While `rd_burst_i` is low, `dq_oe_o` is 2'b00 whatever `mask_i` holds.
- R7: A lane with its output enable set drives the matching byte of `rd_data_i` on `dq_out_o`. A lane without enable drives zero.
- R8: The read mask delay runs every cycle, inside and outside bursts. Masks applied in the two cycles before the first beat of a burst therefore still block those early beats, and masks applied on the last beats land after the burst.
- R9: A synchronous active-low reset fills the read mask delay with the blocked state. During reset, and in the first two cycles after it, `dq_oe_o` stays 2'b00 even with a read burst active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_i | input | 2 | Per-lane byte mask, 1 = blocked |
| wr_burst_i | input | 1 | A write data beat is present this cycle |
| wr_data_i | input | 16 | Write data beat from the pins |
| rd_burst_i | input | 1 | A read data beat is to be driven this cycle |
| rd_data_i | input | 16 | Read data from the array model |
| arr_wr_be_o | output | 2 | Per-lane store enable to the array |
| arr_wr_data_o | output | 16 | Write data to the array |
| dq_oe_o | output | 2 | Per-lane output enable of the data pins |
| dq_out_o | output | 16 | Read data driven to the pins, zero on disabled lanes |

## Verification
The bench builds the block at its defaults: two lanes of eight bits and a read mask delay of two, which is also the only delay for which the in-module latency assertions are generated. With these values the bench runs read bursts of two and eight beats, each placed three cycles after its command cycle. This reaches masks that fall just before the first beat, on each interior beat and on the final beat, including masks that land after the burst has ended. Random mask and data values on both lanes, together with one-hot mask patterns, show whether a mask leaks from one lane into the other.

// File: rtl/sdram_dqm_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and lane helper for the byte-mask data path.
// Assumes lanes are equal-width and packed low lane first.
package sdram_dqm_pkg;
    localparam int unsigned DQM_LANE_W   = 8;
    localparam int unsigned DQM_LANES    = 2;
    localparam int unsigned DQM_RD_DELAY = 2;

    // Replicates each lane-enable bit across its byte of a data word.
    function automatic logic [DQM_LANES*DQM_LANE_W-1:0] lane_expand(
        input logic [DQM_LANES-1:0] en
    );
        logic [DQM_LANES*DQM_LANE_W-1:0] w;
        for (int l = 0; l < DQM_LANES; l++) begin
            w[l*DQM_LANE_W +: DQM_LANE_W] = {DQM_LANE_W{en[l]}};
        end
        return w;
    endfunction
endpackage

// File: rtl/dqm_delay_line.sv
`timescale 1ns/1ps
// Module: dqm_delay_line
// Delays the per-lane mask by DEPTH clocks with a shift register that runs
// every cycle, burst or not. Reset loads all stages with the blocked state.
// Assumes DEPTH >= 1.
module dqm_delay_line #(
    parameter int unsigned LANES = 2,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_i,
    output logic [LANES-1:0] mask_o
);
    logic [LANES-1:0] stage_q [DEPTH];

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_head
                // Captures the live mask into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= mask_i;
                end
            end else begin : g_body
                // Moves the mask one stage further down the line.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign mask_o = stage_q[DEPTH-1];

    // R9: the first clock after a reset clock leaves the head stage blocked.
    a_r9_reset_blocks: assert property (@(posedge clk)
        rst_n && !$past(rst_n) |-> stage_q[0] == '1);
endmodule

// File: rtl/dqm_write_gate.sv
`timescale 1ns/1ps
// Module: dqm_write_gate
// Zero-latency write masking. A lane is stored only while a write beat is
// present and its mask bit is low. Data passes straight to the array.
module dqm_write_gate #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES*LANE_W
) (
    input  logic             wr_burst_i,
    input  logic [LANES-1:0] mask_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [LANES-1:0] be_o,
    output logic [DW-1:0]    data_o
);
    // Forms the store enable of each lane from the burst strobe and its mask.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            be_o[l] = wr_burst_i & ~mask_i[l];
        end
    end

    assign data_o = wr_data_i;
endmodule

// File: rtl/dqm_read_drive.sv
`timescale 1ns/1ps
// Module: dqm_read_drive
// Drives read data per lane. A lane is enabled only during a read beat whose
// delayed mask bit is low, and a disabled lane drives zero.
module dqm_read_drive #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES*LANE_W
) (
    input  logic             rd_burst_i,
    input  logic [LANES-1:0] mask_dly_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic [LANES-1:0] oe_o,
    output logic [DW-1:0]    dq_o
);
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Enables this lane's pins and gates its byte of read data.
            always_comb begin
                oe_o[l] = rd_burst_i & ~mask_dly_i[l];
                dq_o[l*LANE_W +: LANE_W] = oe_o[l] ? rd_data_i[l*LANE_W +: LANE_W]
                                                   : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/sdram_dq_mask_path.sv
`timescale 1ns/1ps
// Module: sdram_dq_mask_path (top)
// Byte-lane mask path of a synchronous DRAM data bus. Writes are masked with
// no latency. Reads are masked through a RD_DELAY-cycle delay line that gates
// per-lane output enables. Assumes the burst strobes come from an external
// sequencer that is already aligned to the data beats.
module sdram_dq_mask_path #(
    parameter int unsigned LANES    = sdram_dqm_pkg::DQM_LANES,
    parameter int unsigned LANE_W   = sdram_dqm_pkg::DQM_LANE_W,
    parameter int unsigned RD_DELAY = sdram_dqm_pkg::DQM_RD_DELAY,
    localparam int unsigned DW      = LANES*LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_i,
    input  logic             wr_burst_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             rd_burst_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic [LANES-1:0] arr_wr_be_o,
    output logic [DW-1:0]    arr_wr_data_o,
    output logic [LANES-1:0] dq_oe_o,
    output logic [DW-1:0]    dq_out_o
);
    logic [LANES-1:0] mask_dly;

    dqm_write_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_wgate (
        .wr_burst_i (wr_burst_i),
        .mask_i     (mask_i),
        .wr_data_i  (wr_data_i),
        .be_o       (arr_wr_be_o),
        .data_o     (arr_wr_data_o)
    );

    dqm_delay_line #(.LANES(LANES), .DEPTH(RD_DELAY)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (mask_i),
        .mask_o (mask_dly)
    );

    dqm_read_drive #(.LANES(LANES), .LANE_W(LANE_W)) u_rdrv (
        .rd_burst_i (rd_burst_i),
        .mask_dly_i (mask_dly),
        .rd_data_i  (rd_data_i),
        .oe_o       (dq_oe_o),
        .dq_o       (dq_out_o)
    );

    // R4: no lane is stored outside a write beat.
    a_r4_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_burst_i |-> arr_wr_be_o == '0);

    // R6: pins stay released outside a read beat.
    a_r6_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_burst_i |-> dq_oe_o == '0);

    // R3: write data reaches the array unchanged.
    a_r3_data_through: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_data_o == wr_data_i);

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_chk
            // R2: a blocked lane is never stored in the same cycle.
            a_r2_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
                mask_i[l] |-> !arr_wr_be_o[l]);
            // R7: a released lane carries zero.
            a_r7_hiz_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !dq_oe_o[l] |-> dq_out_o[l*LANE_W +: LANE_W] == '0);
            if (RD_DELAY == 2) begin : g_lat2
                // R5: a mask two edges back keeps the lane released.
                a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
                    $past(mask_i[l], 2) |-> !dq_oe_o[l]);
            end
        end
    endgenerate
endmodule

// File: tb/sdram_dq_mask_path_test.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random bursts (CAS latency 3, bursts of
// 2 and 8) checked against a model kept in bench functions.
module sdram_dq_mask_path_test;
    localparam int CL = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mask;
    logic        wb, rb;
    logic [15:0] wd, rd;
    logic [1:0]  be, oe;
    logic [15:0] awd, dqo;

    int checks = 0;
    int fails  = 0;
    logic [1:0] m_prev1, m_prev2;

    always #2.5 clk = ~clk;

    sdram_dq_mask_path uut (
        .clk(clk), .rst_n(rst_n), .mask_i(mask), .wr_burst_i(wb), .wr_data_i(wd),
        .rd_burst_i(rb), .rd_data_i(rd), .arr_wr_be_o(be), .arr_wr_data_o(awd),
        .dq_oe_o(oe), .dq_out_o(dqo)
    );

    function automatic logic [1:0] exp_be(input logic w, input logic [1:0] m);
        return w ? ~m : 2'b00;
    endfunction

    function automatic logic [1:0] exp_oe(input logic r, input logic [1:0] m2);
        return r ? ~m2 : 2'b00;
    endfunction

    function automatic logic [15:0] exp_dq(input logic [1:0] e, input logic [15:0] d);
        return {e[1] ? d[15:8] : 8'h00, e[0] ? d[7:0] : 8'h00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive after the edge, update mask history, check mid-cycle.
    task automatic step(input logic r_n, input logic w, input logic r,
                        input logic [1:0] m, input logic [15:0] wdat,
                        input logic [15:0] rdat, input string tag);
        logic [1:0] eoe;
        @(posedge clk);
        #1;
        rst_n = r_n; wb = w; rb = r; mask = m; wd = wdat; rd = rdat;
        #1.5;
        eoe = exp_oe(r, m_prev2);
        if (r_n) begin
            check(be == exp_be(w, m), {tag, " R2 store enable"}, {14'd0, be}, {14'd0, exp_be(w, m)});
            check(awd == wdat, "R3 write data", awd, wdat);
        end
        check(oe == eoe, {tag, " R5 output enable"}, {14'd0, oe}, {14'd0, eoe});
        check(dqo == exp_dq(eoe, rdat), "R7 driven data", dqo, exp_dq(eoe, rdat));
        // History of masks as the delay line sees them (blocked in reset).
        m_prev2 = m_prev1;
        m_prev1 = r_n ? m : 2'b11;
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst_n = 1'b0; wb = 0; rb = 0; mask = 2'b00; wd = '0; rd = '0;
        m_prev1 = 2'b11; m_prev2 = 2'b11;
        @(posedge clk);
        // R9: reset, then read beats with open mask stay released for two cycles.
        step(0, 0, 1, 2'b00, 16'h0000, 16'hA5A5, "R9 in reset");
        step(0, 0, 1, 2'b00, 16'h0000, 16'hA5A5, "R9 in reset");
        step(1, 0, 1, 2'b00, 16'h0000, 16'h1234, "R9 after reset");
        step(1, 0, 1, 2'b00, 16'h0000, 16'h1234, "R9 after reset");
        step(1, 0, 1, 2'b00, 16'h0000, 16'h1234, "R9 open");
        // R1: one-hot masks on writes affect only their own lane.
        step(1, 1, 0, 2'b01, 16'hBEEF, 16'h0, "R1 low lane");
        step(1, 1, 0, 2'b10, 16'hCAFE, 16'h0, "R1 high lane");
        step(1, 1, 0, 2'b00, 16'h0F0F, 16'h0, "R2 both");
        step(1, 1, 0, 2'b11, 16'hF0F0, 16'h0, "R2 none");
        // R4: masks outside a write burst store nothing.
        step(1, 0, 0, 2'b00, 16'h7777, 16'h0, "R4 idle");
        step(1, 0, 0, 2'b10, 16'h7777, 16'h0, "R4 idle");
        // R8: mask set just before a read burst blocks its first beats.
        step(1, 0, 0, 2'b11, 16'h0, 16'h0, "R8 pre");
        step(1, 0, 0, 2'b01, 16'h0, 16'h0, "R8 pre");
        step(1, 0, 1, 2'b00, 16'h0, 16'h1111, "R8 beat0");
        step(1, 0, 1, 2'b00, 16'h0, 16'h2222, "R8 beat1");
        step(1, 0, 1, 2'b10, 16'h0, 16'h3333, "R8 beat2");
        step(1, 0, 1, 2'b01, 16'h0, 16'h4444, "R8 last");
        // R6: masks on the last beats land after the burst; pins stay released.
        step(1, 0, 0, 2'b00, 16'h0, 16'h5555, "R6 after");
        step(1, 0, 0, 2'b00, 16'h0, 16'h6666, "R6 after");
        // Random bursts: reads at CAS latency 3 with burst length 2 or 8.
        for (int b = 0; b < 300; b++) begin
            int bl;
            bit is_rd;
            bl = ($urandom % 2) ? 8 : 2;
            is_rd = $urandom % 2;
            if (is_rd) begin
                for (int c = 0; c < CL; c++)
                    step(1, 0, 0, 2'($urandom), 16'($urandom), 16'($urandom), "R5 rand lead");
                for (int k = 0; k < bl; k++)
                    step(1, 0, 1, 2'($urandom), 16'($urandom), 16'($urandom), "R5 rand read");
            end else begin
                for (int k = 0; k < bl; k++)
                    step(1, 1, 0, 2'($urandom), 16'($urandom), 16'($urandom), "R2 rand write");
            end
            if ($urandom % 3 == 0)
                step(1, 0, 0, 2'($urandom), 16'($urandom), 16'($urandom), "R4 rand gap");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule